// File: doc/BRIEF.md
# Buffered PWM Compare Timer Channel

One timer channel: a free-running up-counter and up to three compare pairs. Each pair has an active compare register and a buffer register. The active registers A, B and E are compared against the counter. The buffers C, D and F hold the next values that software wants to use. Register A sets the period, because the counter returns to zero on the edge after it equals A. Register B sets the duty cycle of a single PWM output.

An 8-bit transfer-mode register holds one timing bit per pair. The bit chooses when that pair's buffer is copied into its active register: at the pair's own compare match, or at the counter clear. Copies happen only while PWM mode is on and buffering is enabled for that pair. This lets software stage new period and duty values and have them take effect cleanly. The E/F pair exists only when the parameter `HAS_EF` is 1.

Top module: `bufPwmTimer`

## Requirements
- R1: After reset, count is 0, pwmOut is 0, the mode register reads 0x00, and all active and buffer registers hold all ones.
- R2: While cntEnable is 1 the counter advances by one on each clock. While cntEnable is 0 it holds its value.
- R3: matchA, matchB and matchE are each high exactly when cntEnable is 1 and count equals the active register A, B or E respectively. matchE is always 0 when HAS_EF is 0.
- R4: On the edge at which matchA is high, the counter loads 0 (the counter clear event).
- R5: pwmOut goes to 1 on the counter clear edge and to 0 on the edge at which matchB is high. When both occur together, 1 wins.
- R6: The mode register has select A at bit 0, select B at bit 1 and select E at bit 2. Bits 7 to 3 always read 0. With HAS_EF = 0, bit 2 reads 0 and ignores writes.
- R7: With a pair's select bit at 0, its buffer is copied into its active register on the edge at which that pair's match is high. The pairs are C to A, D to B and F to E.
- R8: With a pair's select bit at 1, its buffer is copied into its active register on the counter clear edge.
- R9: No copy happens while pwmMode is 0 or while that pair's buffer-enable input is 0. Writing a buffer never changes an active register by itself.
- R10: The register write port addresses A=0, B=1, C=2, D=3, E=4, F=5. A direct write to an active register takes effect on the next edge, except that a copy from the buffer on that same edge takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntEnable | input | 1 | Counter run enable |
| pwmMode | input | 1 | PWM mode; gates all buffer copies |
| bufEnA | input | 1 | Buffer enable for pair A/C |
| bufEnB | input | 1 | Buffer enable for pair B/D |
| bufEnE | input | 1 | Buffer enable for pair E/F |
| modeWrEn | input | 1 | Transfer-mode register write strobe |
| modeWrData | input | 8 | Transfer-mode register write data |
| modeRdData | output | 8 | Transfer-mode register read value |
| regWrEn | input | 1 | Compare/buffer register write strobe |
| regWrSel | input | 3 | Register select for writes (see R10) |
| regWrData | input | CNT_W | Write data |
| count | output | CNT_W | Counter value |
| matchA | output | 1 | Compare match A strobe |
| matchB | output | 1 | Compare match B strobe |
| matchE | output | 1 | Compare match E strobe |
| pwmOut | output | 1 | PWM output |

## Verification
An active register that holds a wrong value shows up at the ports as a match strobe at the wrong count. Because matchA also clears the counter, a wrong A shows as a period of the wrong length. A stuck timing-select bit, or a copy at the wrong moment, first appears in the period after the copy was due. It shows as a match or a PWM edge moved to another count, within one period. A wrong counter or PWM state differs at the ports on the very next clock. The bench therefore compares every output against a behavioural model on every clock, across periods in which the buffers are rewritten under each select setting.

// File: rtl/timerPkg.sv
package timerPkg;
  typedef enum logic [2:0] {
    SEL_A = 3'd0, SEL_B = 3'd1, SEL_C = 3'd2,
    SEL_D = 3'd3, SEL_E = 3'd4, SEL_F = 3'd5
  } regSel_e;

  typedef struct packed {
    logic loadA;
    logic loadB;
    logic loadE;
    logic cntClear;
    logic pwmSet;
    logic pwmClr;
  } strobes_t;
endpackage

// File: rtl/timerCtrl.sv
module timerCtrl #(
  parameter bit HAS_EF = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                matchA,
  input  logic                matchB,
  input  logic                matchE,
  input  logic                pwmMode,
  input  logic                bufEnA,
  input  logic                bufEnB,
  input  logic                bufEnE,
  input  logic                modeWrEn,
  input  logic [7:0]          modeWrData,
  output logic [7:0]          modeRdData,
  output timerPkg::strobes_t  strobes
);
  localparam logic [2:0] SEL_MASK = HAS_EF ? 3'b111 : 3'b011;

  logic [2:0] selReg;
  logic       clearEvt;

  always_ff @(posedge clk) begin
    if (!rstN)          selReg <= '0;
    else if (modeWrEn)  selReg <= modeWrData[2:0] & SEL_MASK;
  end

  // the counter clears on the edge where it matches A
  assign clearEvt = matchA;

  always_comb begin
    strobes.cntClear = clearEvt;
    strobes.pwmSet   = clearEvt;
    strobes.pwmClr   = matchB;
    strobes.loadA    = pwmMode && bufEnA && (selReg[0] ? clearEvt : matchA);
    strobes.loadB    = pwmMode && bufEnB && (selReg[1] ? clearEvt : matchB);
    strobes.loadE    = HAS_EF && pwmMode && bufEnE && (selReg[2] ? clearEvt : matchE);
  end

  assign modeRdData = {5'b0, selReg};
endmodule

// File: rtl/timerDatapath.sv
module timerDatapath #(
  parameter int unsigned CNT_W  = 16,
  parameter bit          HAS_EF = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cntEnable,
  input  logic               regWrEn,
  input  logic [2:0]         regWrSel,
  input  logic [CNT_W-1:0]   regWrData,
  input  timerPkg::strobes_t strobes,
  output logic [CNT_W-1:0]   count,
  output logic               matchA,
  output logic               matchB,
  output logic               matchE,
  output logic               pwmOut,
  output logic [CNT_W-1:0]   actA,
  output logic [CNT_W-1:0]   actB,
  output logic [CNT_W-1:0]   actE
);
  import timerPkg::*;

  localparam logic [CNT_W-1:0] REG_INIT = '1;

  logic [CNT_W-1:0] bufC, bufD;
  logic             wrA, wrB, wrC, wrD;

  assign wrA = regWrEn && (regWrSel == SEL_A);
  assign wrB = regWrEn && (regWrSel == SEL_B);
  assign wrC = regWrEn && (regWrSel == SEL_C);
  assign wrD = regWrEn && (regWrSel == SEL_D);

  always_ff @(posedge clk) begin
    if (!rstN)                 count <= '0;
    else if (strobes.cntClear) count <= '0;
    else if (cntEnable)        count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actA <= REG_INIT; actB <= REG_INIT;
      bufC <= REG_INIT; bufD <= REG_INIT;
    end else begin
      if (strobes.loadA) actA <= bufC;
      else if (wrA)      actA <= regWrData;
      if (strobes.loadB) actB <= bufD;
      else if (wrB)      actB <= regWrData;
      if (wrC) bufC <= regWrData;
      if (wrD) bufD <= regWrData;
    end
  end

  assign matchA = cntEnable && (count == actA);
  assign matchB = cntEnable && (count == actB);

  generate
    if (HAS_EF) begin : g_ef
      logic [CNT_W-1:0] regE, bufF;
      logic             wrE, wrF;
      assign wrE = regWrEn && (regWrSel == SEL_E);
      assign wrF = regWrEn && (regWrSel == SEL_F);
      always_ff @(posedge clk) begin
        if (!rstN) begin
          regE <= REG_INIT; bufF <= REG_INIT;
        end else begin
          if (strobes.loadE) regE <= bufF;
          else if (wrE)      regE <= regWrData;
          if (wrF) bufF <= regWrData;
        end
      end
      assign actE   = regE;
      assign matchE = cntEnable && (count == regE);
    end else begin : g_noEf
      assign actE   = '0;
      assign matchE = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)               pwmOut <= 1'b0;
    else if (strobes.pwmSet) pwmOut <= 1'b1;
    else if (strobes.pwmClr) pwmOut <= 1'b0;
  end
endmodule

// File: rtl/bufPwmTimer.sv
module bufPwmTimer #(
  parameter int unsigned CNT_W  = 16,
  parameter bit          HAS_EF = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEnable,
  input  logic             pwmMode,
  input  logic             bufEnA,
  input  logic             bufEnB,
  input  logic             bufEnE,
  input  logic             modeWrEn,
  input  logic [7:0]       modeWrData,
  output logic [7:0]       modeRdData,
  input  logic             regWrEn,
  input  logic [2:0]       regWrSel,
  input  logic [CNT_W-1:0] regWrData,
  output logic [CNT_W-1:0] count,
  output logic             matchA,
  output logic             matchB,
  output logic             matchE,
  output logic             pwmOut
);
  timerPkg::strobes_t strobes;
  logic [CNT_W-1:0]   actA, actB, actE;

  timerCtrl #(.HAS_EF(HAS_EF)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .matchA(matchA), .matchB(matchB), .matchE(matchE),
    .pwmMode(pwmMode), .bufEnA(bufEnA), .bufEnB(bufEnB), .bufEnE(bufEnE),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .modeRdData(modeRdData), .strobes(strobes)
  );

  timerDatapath #(.CNT_W(CNT_W), .HAS_EF(HAS_EF)) u_dp (
    .clk(clk), .rstN(rstN), .cntEnable(cntEnable),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .strobes(strobes), .count(count),
    .matchA(matchA), .matchB(matchB), .matchE(matchE),
    .pwmOut(pwmOut), .actA(actA), .actB(actB), .actE(actE)
  );
endmodule

// File: rtl/timerChecker.sv
module timerChecker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntEnable,
  input logic             pwmMode,
  input logic             regWrEn,
  input logic [2:0]       regWrSel,
  input logic [CNT_W-1:0] count,
  input logic             matchA,
  input logic             matchB,
  input logic             matchE,
  input logic             pwmOut,
  input logic [7:0]       modeRdData,
  input logic [CNT_W-1:0] actA
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cntEnable |=> $stable(count));

  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cntEnable && !matchA) |=> count == CNT_W'($past(count) + 1'b1));

  p_idle_nomatch_r3: assert property (@(posedge clk) disable iff (!rstN)
    !cntEnable |-> !(matchA || matchB || matchE));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    matchA |=> count == '0);

  p_pwm_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    matchA |=> pwmOut);

  p_pwm_clr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (matchB && !matchA) |=> !pwmOut);

  p_reserved_r6: assert property (@(posedge clk) disable iff (!rstN)
    modeRdData[7:3] == 5'b0);

  p_no_copy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!pwmMode && !(regWrEn && regWrSel == 3'd0)) |=> $stable(actA));
endmodule

bind bufPwmTimer timerChecker #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .cntEnable(cntEnable), .pwmMode(pwmMode),
  .regWrEn(regWrEn), .regWrSel(regWrSel), .count(count),
  .matchA(matchA), .matchB(matchB), .matchE(matchE), .pwmOut(pwmOut),
  .modeRdData(modeRdData), .actA(actA)
);

// File: tb/test_bufPwmTimer.sv
`timescale 1ns/1ps
module test_bufPwmTimer;
  localparam int W = 16;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0, rstN = 1'b0;
  logic cntEnable = 0, pwmMode = 0, bufEnA = 0, bufEnB = 0, bufEnE = 0;
  logic modeWrEn = 0, regWrEn = 0;
  logic [7:0] modeWrData = '0;
  logic [2:0] regWrSel = '0;
  logic [W-1:0] regWrData = '0;
  logic [7:0] modeRdData, modeRd2;
  logic [W-1:0] count, count2;
  logic matchA, matchB, matchE, pwmOut, mA2, mB2, mE2, pwm2;

  int checks = 0, errors = 0;

  // reference model state
  logic [W-1:0] mCnt, mA, mB, mE, mC, mD, mF;
  logic [2:0]   mSel;
  logic         mPwm;

  always #4 clk = ~clk;

  bufPwmTimer #(.CNT_W(W), .HAS_EF(1'b1)) i_bufPwmTimer (
    .clk(clk), .rstN(rstN), .cntEnable(cntEnable), .pwmMode(pwmMode),
    .bufEnA(bufEnA), .bufEnB(bufEnB), .bufEnE(bufEnE),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData), .modeRdData(modeRdData),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .count(count), .matchA(matchA), .matchB(matchB), .matchE(matchE),
    .pwmOut(pwmOut)
  );

  // variant without the E/F pair, used for the mode register read-back
  bufPwmTimer #(.CNT_W(W), .HAS_EF(1'b0)) i_noEf (
    .clk(clk), .rstN(rstN), .cntEnable(1'b0), .pwmMode(1'b0),
    .bufEnA(1'b0), .bufEnB(1'b0), .bufEnE(1'b0),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData), .modeRdData(modeRd2),
    .regWrEn(1'b0), .regWrSel(3'd0), .regWrData('0),
    .count(count2), .matchA(mA2), .matchB(mB2), .matchE(mE2), .pwmOut(pwm2)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // compare at the negedge, advance the model, move to the next negedge
  task automatic tick(string tag);
    logic eA, eB, eE, ldA, ldB, ldE;
    eA = cntEnable && (mCnt == mA);
    eB = cntEnable && (mCnt == mB);
    eE = cntEnable && (mCnt == mE);
    chk({tag, "/R2"}, "count", int'(count), int'(mCnt));
    chk({tag, "/R3"}, "matchA", int'(matchA), int'(eA));
    chk({tag, "/R3"}, "matchB", int'(matchB), int'(eB));
    chk({tag, "/R3"}, "matchE", int'(matchE), int'(eE));
    chk({tag, "/R5"}, "pwmOut", int'(pwmOut), int'(mPwm));
    chk({tag, "/R6"}, "modeRd", int'(modeRdData), int'({5'b0, mSel}));
    chk({tag, "/R6"}, "modeRdNoEf", int'(modeRd2), int'({5'b0, mSel & 3'b011}));
    ldA = pwmMode && bufEnA && (mSel[0] ? eA : eA);
    ldB = pwmMode && bufEnB && (mSel[1] ? eA : eB);
    ldE = pwmMode && bufEnE && (mSel[2] ? eA : eE);
    if (eA) mCnt = '0; else if (cntEnable) mCnt = mCnt + 1'b1;
    if (eA) mPwm = 1'b1; else if (eB) mPwm = 1'b0;
    if (ldA) mA = mC; else if (regWrEn && regWrSel == 3'd0) mA = regWrData;
    if (ldB) mB = mD; else if (regWrEn && regWrSel == 3'd1) mB = regWrData;
    if (ldE) mE = mF; else if (regWrEn && regWrSel == 3'd4) mE = regWrData;
    if (regWrEn && regWrSel == 3'd2) mC = regWrData;
    if (regWrEn && regWrSel == 3'd3) mD = regWrData;
    if (regWrEn && regWrSel == 3'd5) mF = regWrData;
    if (modeWrEn) mSel = modeWrData[2:0];
    @(negedge clk);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic wrReg(logic [2:0] sel, int val, string tag);
    regWrEn = 1'b1; regWrSel = sel; regWrData = W'(val);
    tick(tag);
    regWrEn = 1'b0;
  endtask

  task automatic wrMode(logic [7:0] val, string tag);
    modeWrEn = 1'b1; modeWrData = val;
    tick(tag);
    modeWrEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    mCnt = '0; mA = ONES; mB = ONES; mE = ONES; mC = ONES; mD = ONES; mF = ONES;
    mSel = '0; mPwm = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "count", int'(count), 0);
    chk("R1", "pwmOut", int'(pwmOut), 0);
    chk("R1", "modeRd", int'(modeRdData), 0);
    chk("R1", "matchA", int'(matchA), 0);
    rstN = 1'b1;
    run(2, "R1");

    // R10: direct writes to active registers, then free run
    wrReg(3'd0, 9, "R10");
    wrReg(3'd1, 4, "R10");
    wrReg(3'd4, 6, "R10");
    cntEnable = 1'b1;
    run(25, "R4");
    cntEnable = 1'b0;
    run(3, "R2");
    cntEnable = 1'b1;
    run(5, "R2");

    // R7: buffered, copy on own match
    pwmMode = 1'b1; bufEnA = 1'b1; bufEnB = 1'b1; bufEnE = 1'b1;
    wrReg(3'd2, 7, "R7");
    wrReg(3'd3, 2, "R7");
    wrReg(3'd5, 3, "R7");
    run(30, "R7");

    // R8: copy on counter clear; reserved and bit2 behaviour (R6)
    wrMode(8'hFF, "R6");
    wrReg(3'd2, 11, "R8");
    wrReg(3'd3, 8, "R8");
    wrReg(3'd5, 5, "R8");
    run(30, "R8");
    wrReg(3'd3, 1, "R8");
    run(15, "R8");

    // R9: no copy when PWM mode off, or per-pair enable off
    pwmMode = 1'b0;
    wrReg(3'd2, 5, "R9");
    wrReg(3'd3, 3, "R9");
    run(25, "R9");
    pwmMode = 1'b1; bufEnA = 1'b0;
    wrReg(3'd2, 4, "R9");
    run(25, "R9");

    // R10: copy and direct write on the same edge; mode bit pattern change
    bufEnA = 1'b1;
    wrMode(8'h02, "R6");
    wrReg(3'd2, 13, "R10");
    while (!(cntEnable && mCnt == mA)) tick("R10");
    wrReg(3'd0, 20, "R10");
    run(20, "R10");

    // R5: B equal to A, set wins
    pwmMode = 1'b0;
    wrReg(3'd0, 12, "R5");
    wrReg(3'd1, 12, "R5");
    run(30, "R5");
    wrReg(3'd1, 5, "R5");
    run(30, "R5");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule